// File: doc/BRIEF.md
# Synchronous bus clock prescaler

This block produces the timing of four synchronous clock domains from a single main clock: the CPU domain, the high-speed bus domain and two peripheral bus domains (A and B). The main clock is taken from one of two source tick inputs, an oscillator or a PLL, under a select bit. Each domain either follows the main clock or divides it by a power of two. Every domain output is a clock-enable pulse in the system clock, not a derived clock. Downstream logic uses the pulses as qualifiers.

Each domain also owns a per-module gating mask. The mask turns the domain pulse into one enable per module, and software changes a single module by read-modify-write of the mask word. The divider settings form a hierarchy. The high-speed bus never runs faster than the CPU, and neither peripheral bus runs faster than the high-speed bus. A control write that would break this order is refused and recorded in a sticky error flag. An accepted divider setting waits in a pending register. It becomes active only at the point where every possible domain period ends together, so no domain ever produces a short period.

Top module: `bus_clk_prescaler`

## Requirements
- R1: Register address 0, bit 0 selects the main tick: 1 takes `pll_tick`, 0 takes `osc_tick`. The unselected input has no effect on `dom_en`.
- R2: A domain whose divide bit is clear pulses on every main tick, and stays high continuously while the main tick is continuously high.
- R3: Register address 1 holds four 4-bit fields, {divide bit, 3-bit shift}. The CPU field is at bits 3:0, the high-speed bus at 7:4, peripheral A at 11:8 and peripheral B at 15:12. When the divide bit of a domain is set, the domain pulses exactly once every 2^(shift+1) main ticks.
- R4: A peripheral domain pulses only in cycles where the high-speed bus pulses, and the high-speed bus pulses only in cycles where the CPU pulses.
- R5: A write to address 1 is refused when the resulting divide ratios give CPU > high-speed bus, or high-speed bus > either peripheral bus. A refused write leaves the stored setting unchanged and sets `cfg_err`. `cfg_err` stays set until reset.
- R6: An accepted divider setting takes effect only after the main tick on which a free 8-bit main-tick counter reaches 255. Earlier ticks keep the old setting.
- R7: Addresses 4, 5, 6 and 7 hold the 32-bit module masks of the CPU, high-speed bus, peripheral A and peripheral B domains. `mod_ce[32*d+n]` equals `dom_en[d]` AND mask bit n of domain d. A mask write acts from the next cycle.
- R8: Reset selects the oscillator, clears every divide field, sets every mask bit and clears `cfg_err`.
- R9: Reads are combinational. Address 0 returns the select bit, address 1 returns the stored divider word, addresses 4 to 7 return the masks, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator tick enable |
| pll_tick | input | 1 | PLL tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| dom_en | output | 4 | Domain enables: bit 0 CPU, 1 high-speed bus, 2 peripheral A, 3 peripheral B |
| mod_ce | output | 128 | Per-module enables, 32 per domain |
| cfg_err | output | 1 | Sticky refused-write flag |

## Verification
Register writes land at the clock edge that captures `wr_en`. Select changes, mask changes and the error flag are visible in the next cycle, and reads are visible within the same cycle. The bench samples all of these 1 ns after the falling edge that ends the write. A divider change is due only after the next counter wrap, which can be up to 256 main ticks away. The bench therefore waits 260 cycles before it counts pulses over a 256-cycle window. In one directed case it starts the counter from a known zero, which lets it check that the first 255 ticks still follow the old setting.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
    localparam int NDOM  = 4;
    localparam int SEL_W = 3;
    localparam int CFG_W = SEL_W + 1;
    localparam int CNT_W = 2 ** SEL_W;

    typedef enum logic [1:0] {
        DOM_CPU = 2'd0,
        DOM_HSB = 2'd1,
        DOM_PBA = 2'd2,
        DOM_PBB = 2'd3
    } dom_e;

    typedef struct packed {
        logic             div;
        logic [SEL_W-1:0] sel;
    } divcfg_t;

    typedef divcfg_t [NDOM-1:0] divset_t;

    // Effective right shift of the main rate: 0 when undivided, sel+1 otherwise
    function automatic logic [SEL_W:0] shift_of(divcfg_t c);
        return c.div ? ({1'b0, c.sel} + 1'b1) : '0;
    endfunction

    // Children may never be faster (smaller shift) than their parent
    function automatic logic order_ok(divset_t s);
        return (shift_of(s[DOM_CPU]) <= shift_of(s[DOM_HSB])) &&
               (shift_of(s[DOM_HSB]) <= shift_of(s[DOM_PBA])) &&
               (shift_of(s[DOM_HSB]) <= shift_of(s[DOM_PBB]));
    endfunction

    // Low bits of the tick counter that must all be one for a pulse
    function automatic logic [CNT_W-1:0] low_mask(logic [SEL_W:0] s);
        logic [CNT_W:0]   one_hot;
        logic [CNT_W-1:0] unit;
        unit    = {{(CNT_W-1){1'b0}}, 1'b1};
        one_hot = {{CNT_W{1'b0}}, 1'b1} << s;
        return one_hot[CNT_W-1:0] - unit;
    endfunction
endpackage

// File: rtl/clkpre_regs.sv
module clkpre_regs
    import clkpre_pkg::*;
#(
    parameter int DW     = 32,
    parameter int N_MOD  = 32,
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic                       main_sel,
    output divset_t                    pend_cfg,
    output logic [NDOM-1:0][N_MOD-1:0] mask,
    output logic                       cfg_err
);
    localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(1);
    localparam int MASK_BASE = 4;

    divset_t wcfg;
    assign wcfg = divset_t'(wdata[NDOM*CFG_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            main_sel <= 1'b0;
            pend_cfg <= '0;
            mask     <= '1;
            cfg_err  <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_MAIN) begin
                main_sel <= wdata[0];
            end else if (addr == A_DIV) begin
                if (order_ok(wcfg)) pend_cfg <= wcfg;
                else                cfg_err  <= 1'b1;
            end
            for (int d = 0; d < NDOM; d++) begin
                if (addr == ADDR_W'(MASK_BASE + d)) mask[d] <= wdata[N_MOD-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MAIN) rdata[0] = main_sel;
        if (addr == A_DIV)  rdata[NDOM*CFG_W-1:0] = pend_cfg;
        for (int d = 0; d < NDOM; d++) begin
            if (addr == ADDR_W'(MASK_BASE + d)) rdata[N_MOD-1:0] = mask[d];
        end
    end
endmodule

// File: rtl/clkpre_divider.sv
module clkpre_divider
    import clkpre_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            main_tick,
    input  divset_t         pend_cfg,
    output logic [NDOM-1:0] dom_en
);
    logic [CNT_W-1:0] cnt;
    divset_t          act_cfg;
    logic             boundary;

    // Every possible domain period ends when the counter is all ones
    assign boundary = main_tick && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_cfg <= '0;
        end else begin
            if (main_tick) cnt <= cnt + 1'b1;
            if (boundary)  act_cfg <= pend_cfg;
        end
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        logic [CNT_W-1:0] need;
        assign need      = low_mask(shift_of(act_cfg[d]));
        assign dom_en[d] = main_tick && ((cnt & need) == need);
    end
endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
    import clkpre_pkg::*;
#(
    parameter int DW     = 32,
    parameter int N_MOD  = 32,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    osc_tick,
    input  logic                    pll_tick,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic [NDOM-1:0]         dom_en,
    output logic [NDOM*N_MOD-1:0]   mod_ce,
    output logic                    cfg_err
);
    logic                       main_sel;
    logic                       main_tick;
    divset_t                    pend_cfg;
    logic [NDOM-1:0][N_MOD-1:0] mask;

    clkpre_regs #(.DW(DW), .N_MOD(N_MOD), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .main_sel(main_sel),
        .pend_cfg(pend_cfg),
        .mask    (mask),
        .cfg_err (cfg_err)
    );

    assign main_tick = main_sel ? pll_tick : osc_tick;

    clkpre_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .main_tick(main_tick),
        .pend_cfg (pend_cfg),
        .dom_en   (dom_en)
    );

    for (genvar d = 0; d < NDOM; d++) begin : g_gate
        assign mod_ce[d*N_MOD +: N_MOD] = mask[d] & {N_MOD{dom_en[d]}};
    end
endmodule

// File: rtl/bus_clk_prescaler_chk.sv
module bus_clk_prescaler_chk
    import clkpre_pkg::*;
#(
    parameter int N_MOD = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  osc_tick,
    input logic                  pll_tick,
    input logic [NDOM-1:0]       dom_en,
    input logic [NDOM*N_MOD-1:0] mod_ce,
    input logic                  cfg_err
);
    // R4
    hsb_nest_chk: assert property (@(posedge clk) disable iff (rst)
        dom_en[DOM_HSB] |-> dom_en[DOM_CPU]);
    // R4
    pba_nest_chk: assert property (@(posedge clk) disable iff (rst)
        dom_en[DOM_PBA] |-> dom_en[DOM_HSB]);
    // R4
    pbb_nest_chk: assert property (@(posedge clk) disable iff (rst)
        dom_en[DOM_PBB] |-> dom_en[DOM_HSB]);
    // R1
    tick_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|dom_en) |-> (osc_tick || pll_tick));
    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);
    // R8
    err_reset_chk: assert property (@(posedge clk)
        rst |=> !cfg_err);

    for (genvar d = 0; d < NDOM; d++) begin : g_mod
        // R7
        mod_gate_chk: assert property (@(posedge clk) disable iff (rst)
            (|mod_ce[d*N_MOD +: N_MOD]) |-> dom_en[d]);
    end
endmodule

bind bus_clk_prescaler bus_clk_prescaler_chk #(.N_MOD(N_MOD)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .osc_tick(osc_tick),
    .pll_tick(pll_tick),
    .dom_en  (dom_en),
    .mod_ce  (mod_ce),
    .cfg_err (cfg_err)
);

// File: tb/tb_bus_clk_prescaler.sv
module tb_bus_clk_prescaler;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         osc_tick = 1'b0;
    logic         pll_tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [3:0]   dom_en;
    logic [127:0] mod_ce;
    logic         cfg_err;

    int total = 0;
    int bad   = 0;

    bus_clk_prescaler dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .dom_en(dom_en), .mod_ce(mod_ce), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [15:0] w;
        logic [15:0] rb;
        logic        e;
        logic [8:0]  c0;
        logic [8:0]  c1;
        logic [8:0]  c2;
        logic [8:0]  c3;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'h8980, 16'h8980, 1'b0, 9'd256, 9'd128, 9'd64, 9'd128},
        '{16'h0888, 16'h8980, 1'b1, 9'd256, 9'd128, 9'd64, 9'd128},
        '{16'hCFAA, 16'hCFAA, 1'b1, 9'd32,  9'd32,  9'd1,  9'd8},
        '{16'h0000, 16'h0000, 1'b1, 9'd256, 9'd256, 9'd256, 9'd256}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_win(output int n0, output int n1, output int n2, output int n3);
        n0 = 0; n1 = 0; n2 = 0; n3 = 0;
        for (int i = 0; i < 256; i++) begin
            #1;
            n0 += int'(dom_en[0]); n1 += int'(dom_en[1]);
            n2 += int'(dom_en[2]); n3 += int'(dom_en[3]);
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n0, n1, n2, n3;

        // Reset state with both sources stopped
        do_reset();
        #1;
        chk("R8 err", 32'(cfg_err), 32'd0);
        chk("R1 no tick no pulse", 32'(dom_en), 32'h0);
        rd(3'd0, v); chk("R8 select", v, 32'd0);
        rd(3'd1, v); chk("R8 divider", v, 32'd0);
        for (int d = 0; d < 4; d++) begin
            rd(3'(4 + d), v); chk("R8 mask", v, 32'hFFFF_FFFF);
        end
        rd(3'd2, v); chk("R9 unused address", v, 32'd0);

        // Deferred activation: counter frozen at 0, then oscillator runs
        wr(3'd1, 32'h0000_8980);
        osc_tick = 1'b1;
        n1 = 0;
        for (int i = 0; i < 255; i++) begin
            #1 n1 += int'(dom_en[1]);
            @(negedge clk);
        end
        chk("R6 old setting before wrap", 32'(n1), 32'd255);
        count_win(n0, n1, n2, n3);
        chk("R6 new cpu", 32'(n0), 32'd256);
        chk("R6 new hsb", 32'(n1), 32'd128);
        chk("R6 new pba", 32'(n2), 32'd64);

        // Table of divider words
        foreach (VECS[k]) begin
            wr(3'd1, {16'h0, VECS[k].w});
            #1 chk("R5 err flag", 32'(cfg_err), 32'(VECS[k].e));
            rd(3'd1, v); chk("R9 divider readback", v, {16'h0, VECS[k].rb});
            repeat (260) @(negedge clk);
            count_win(n0, n1, n2, n3);
            chk("R3 cpu rate", 32'(n0), 32'(VECS[k].c0));
            chk("R3 hsb rate", 32'(n1), 32'(VECS[k].c1));
            chk("R3 pba rate", 32'(n2), 32'(VECS[k].c2));
            chk("R3 pbb rate", 32'(n3), 32'(VECS[k].c3));
        end

        // Undivided, oscillator continuously high
        #1 chk("R2 held high", 32'(dom_en), 32'hF);

        // Single-bit read-modify-write of the high-speed bus mask
        rd(3'd5, v);
        v[2] = 1'b0;
        wr(3'd5, v);
        #1;
        chk("R7 gated module", 32'(mod_ce[34]), 32'd0);
        chk("R7 neighbour module", 32'(mod_ce[35]), 32'd1);
        chk("R7 other domain", 32'(mod_ce[2]), 32'd1);
        rd(3'd5, v); chk("R9 mask readback", v, 32'hFFFF_FFFB);

        // Main clock select
        wr(3'd0, 32'd1);
        pll_tick = 1'b0;
        #1 chk("R1 pll selected, osc ignored", 32'(dom_en), 32'h0);
        @(negedge clk);
        pll_tick = 1'b1; osc_tick = 1'b0;
        #1 chk("R1 pll drives", 32'(dom_en), 32'hF);
        rd(3'd0, v); chk("R9 select readback", v, 32'd1);

        // Reset clears sticky error and restores defaults
        do_reset();
        #1 chk("R5 err cleared by reset", 32'(cfg_err), 32'd0);
        rd(3'd0, v); chk("R8 select after reset", v, 32'd0);
        rd(3'd5, v); chk("R8 mask after reset", v, 32'hFFFF_FFFF);
        #1 chk("R1 osc back, stopped", 32'(dom_en), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule